// File: doc/BRIEF.md
# MDIO management bus master

This block is the master side of the two-wire station-management bus that a MAC uses to reach PHY registers. It derives the management clock (MDC) from the system clock with a half-period divider and drives or releases the bidirectional data line through three separate signals: a data output, an output enable and a sampled input. A host issues one access at a time through a request strobe that carries the direction, the framing clause, a 5-bit PHY address, a 5-bit register or device number, a 16-bit extended address and the write data. When the access completes, the block pulses `done` and presents the read data and an error flag.

Clause 22 accesses are a single frame. A Clause 45 access is two frames: an address frame that loads the PHY's 16-bit address pointer, then the read or write frame. On reads the block samples the turnaround bit that the PHY must pull low. If that bit is high and the PHY's bit in the per-PHY ignore mask is clear, the block clocks a fixed number of extra bits to flush the PHY, returns all-ones and flags an error.

The control is one state machine. `IDLE` accepts a request and goes to `PRE`. `PRE` sends the preamble and moves to `HDR`. `HDR` sends start, opcode, PHY and register fields. After `HDR`, a frame that carries outgoing data (a write, or a Clause 45 address frame) goes to `WDAT`, which sends the turnaround and 16 data bits. A read goes to `TA` instead. From `TA`, a low turnaround or a masked PHY leads to `RDAT`, and a high, unmasked turnaround leads to `FLUSH`. `RDAT` and `WDAT` both end in `TAIL`, a released idle clock. `TAIL` returns to `PRE` if the address frame of a Clause 45 access has just ended, and goes to `DONE` otherwise. `FLUSH` ends in `DONE`, and `DONE` returns to `IDLE` after one cycle. Each state change happens on the system-clock cycle in which MDC falls at the end of a bit.

Top module: `mdio_master`

## Requirements
- R1: While `ready` is high, a request is accepted on `req_valid`. In the next cycle `ready` drops and the block drives a preamble of exactly 32 one bits, each on its own MDC clock.
- R2: A Clause 22 frame sends start bits 01, then opcode 10 for a read or 01 for a write, then the 5-bit PHY address and the 5-bit register number. Each field is sent most significant bit first, so PHY address 31 and register 31 appear as five ones each.
- R3: A Clause 45 access sends an address frame first: start 00, opcode 00, the device number in the register field and `req_addr` as data. It then sends a second frame with start 00 and opcode 11 for a read or 01 for a write, using the same PHY and device fields.
- R4: On writes and address frames, the header is followed by turnaround bits 1 then 0 and 16 data bits, most significant bit first. The block then releases the line for one idle clock. A Clause 22 write takes 65 MDC rising edges in total, and a Clause 45 write takes 130.
- R5: On a read, the line is released after the register field and one turnaround bit is sampled. If that bit is 0, the block shifts in 16 bits, most significant bit first, clocks one trailing cycle and returns the data with `err` low. A Clause 22 read takes 64 MDC rising edges, and a Clause 45 read takes 129.
- R6: If the sampled turnaround bit is 1 and the PHY's mask bit is clear, the block clocks 32 more bits, discards them, and reports `rdata` = 0xFFFF with `err` high. This access takes 79 MDC rising edges.
- R7: Bit n of `ta_ignore_mask`, sampled at request time, makes the turnaround check pass for PHY address n only. The read then returns the PHY's 16 data bits with `err` low.
- R8: MDC idles low, and each MDC high and low phase lasts `HALF_DIV` system clocks. The driven data value changes only while MDC is low, and read data is sampled in the cycle in which MDC falls.
- R9: `mdio_oe` is low in reset, while idle, and through the turnaround, read data, flush and trailing cycles, so the master never drives while the PHY does.
- R10: `done` is a single-cycle pulse, and `ready` is high in the cycle after it. A `req_valid` that arrives while busy is ignored: it starts no frame and changes no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while `ready` is high |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_c45 | input | 1 | 1 = Clause 45 two-frame access, 0 = Clause 22 |
| req_phy | input | 5 | PHY address |
| req_dev | input | 5 | Register number (Clause 22) or device number (Clause 45) |
| req_addr | input | 16 | Clause 45 register address sent in the address frame |
| req_wdata | input | 16 | Write data |
| ta_ignore_mask | input | 32 | Per-PHY turnaround-check override, bit n for PHY n |
| ready | output | 1 | Idle and able to accept a request |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Turnaround failure on the last read |
| rdata | output | 16 | Read data of the last access |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data value driven onto the line |
| mdio_oe | output | 1 | Output enable for `mdio_o` |
| mdio_i | input | 1 | Sampled line value |

## Verification
The hardest path to reach from the ports is the turnaround failure. It needs a PHY that answers a read and also leaves the turnaround bit high, and it must be told apart from the masked override, which follows the same wire pattern. The bench's PHY responder therefore drives the turnaround bit high for one chosen address but still returns real data after it. The flush path then shows up as 0xFFFF with the error flag set and 79 MDC edges. Setting that PHY's mask bit instead yields the real data in 64 edges, and setting the mask bit of a neighbouring PHY leaves the error in place.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int DATA_W   = 16;
    localparam int HDR_BITS = 14;  // start(2) + opcode(2) + phy(5) + reg(5)
    localparam int WR_BITS  = 18;  // turnaround(2) + data(16)

    localparam logic [1:0] ST_C22    = 2'b01;
    localparam logic [1:0] ST_C45    = 2'b00;
    localparam logic [1:0] OP_C22_RD = 2'b10;
    localparam logic [1:0] OP_WR     = 2'b01;
    localparam logic [1:0] OP_C45_AD = 2'b00;
    localparam logic [1:0] OP_C45_RD = 2'b11;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PRE,
        S_HDR,
        S_WDAT,
        S_TA,
        S_RDAT,
        S_FLUSH,
        S_TAIL,
        S_DONE
    } mdio_state_e;

    // Outgoing bit stream after the preamble, MSB sent first.
    function automatic logic [31:0] pack_frame(
        input logic [1:0]  st,
        input logic [1:0]  op,
        input logic [4:0]  phy,
        input logic [4:0]  fld,
        input logic [15:0] data
    );
        return {st, op, phy, fld, 2'b10, data};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int HALF_DIV = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic fall
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick = run && (cnt == CW'(HALF_DIV - 1));
    assign fall = tick && mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_pkg::*;
#(
    parameter int PRE_LEN   = 32,
    parameter int FLUSH_LEN = 32,
    parameter int NUM_PHY   = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_end,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic                 req_c45,
    input  logic [4:0]           req_phy,
    input  logic [4:0]           req_dev,
    input  logic [DATA_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [NUM_PHY-1:0]   ta_ignore_mask,
    input  logic                 mdio_i,
    output logic                 run,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    output logic                 ready,
    output logic                 done,
    output logic                 err,
    output logic [DATA_W-1:0]    rdata
);
    localparam int CNT_MAX = (PRE_LEN > FLUSH_LEN) ? PRE_LEN : FLUSH_LEN;
    localparam int CNT_W   = $clog2((CNT_MAX > WR_BITS) ? CNT_MAX : WR_BITS) + 1;

    mdio_state_e       state;
    logic [CNT_W-1:0]  cnt;
    logic [31:0]       tx_sh;
    logic [DATA_W-2:0] rx_sh;
    logic              wr_q;
    logic              addr_phase_q;
    logic              ign_q;
    logic [4:0]        phy_q;
    logic [4:0]        dev_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              err_q;

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state        <= S_IDLE;
            cnt          <= '0;
            tx_sh        <= '0;
            rx_sh        <= '0;
            wr_q         <= 1'b0;
            addr_phase_q <= 1'b0;
            ign_q        <= 1'b0;
            phy_q        <= '0;
            dev_q        <= '0;
            wdata_q      <= '0;
            rdata_q      <= '0;
            err_q        <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        wr_q         <= req_write;
                        addr_phase_q <= req_c45;
                        ign_q        <= ta_ignore_mask[req_phy];
                        phy_q        <= req_phy;
                        dev_q        <= req_dev;
                        wdata_q      <= req_wdata;
                        rdata_q      <= '0;
                        err_q        <= 1'b0;
                        tx_sh        <= req_c45
                            ? pack_frame(ST_C45, OP_C45_AD, req_phy, req_dev, req_addr)
                            : pack_frame(ST_C22, req_write ? OP_WR : OP_C22_RD,
                                         req_phy, req_dev, req_wdata);
                        cnt          <= CNT_W'(PRE_LEN - 1);
                        state        <= S_PRE;
                    end
                end
                S_PRE: begin
                    if (bit_end) begin
                        if (cnt == '0) begin
                            cnt   <= CNT_W'(HDR_BITS - 1);
                            state <= S_HDR;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                end
                S_HDR: begin
                    if (bit_end) begin
                        tx_sh <= {tx_sh[30:0], 1'b0};
                        if (cnt == '0) begin
                            if (wr_q || addr_phase_q) begin
                                cnt   <= CNT_W'(WR_BITS - 1);
                                state <= S_WDAT;
                            end else begin
                                state <= S_TA;
                            end
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                end
                S_WDAT: begin
                    if (bit_end) begin
                        tx_sh <= {tx_sh[30:0], 1'b0};
                        if (cnt == '0) state <= S_TAIL;
                        else           cnt   <= cnt - 1'b1;
                    end
                end
                S_TA: begin
                    if (bit_end) begin
                        if (!mdio_i || ign_q) begin
                            cnt   <= CNT_W'(DATA_W - 1);
                            state <= S_RDAT;
                        end else begin
                            cnt   <= CNT_W'(FLUSH_LEN - 1);
                            state <= S_FLUSH;
                        end
                    end
                end
                S_RDAT: begin
                    if (bit_end) begin
                        rx_sh <= {rx_sh[DATA_W-3:0], mdio_i};
                        if (cnt == '0) begin
                            rdata_q <= {rx_sh, mdio_i};
                            state   <= S_TAIL;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                end
                S_FLUSH: begin
                    if (bit_end) begin
                        if (cnt == '0) begin
                            rdata_q <= '1;
                            err_q   <= 1'b1;
                            state   <= S_DONE;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                end
                S_TAIL: begin
                    if (bit_end) begin
                        if (addr_phase_q) begin
                            addr_phase_q <= 1'b0;
                            tx_sh        <= pack_frame(ST_C45, wr_q ? OP_WR : OP_C45_RD,
                                                       phy_q, dev_q, wdata_q);
                            cnt          <= CNT_W'(PRE_LEN - 1);
                            state        <= S_PRE;
                        end else begin
                            state <= S_DONE;
                        end
                    end
                end
                S_DONE: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Moore outputs
    always_comb begin
        ready   = 1'b0;
        done    = 1'b0;
        run     = 1'b1;
        mdio_oe = 1'b0;
        mdio_o  = 1'b0;
        unique case (state)
            S_IDLE: begin
                ready = 1'b1;
                run   = 1'b0;
            end
            S_PRE: begin
                mdio_oe = 1'b1;
                mdio_o  = 1'b1;
            end
            S_HDR, S_WDAT: begin
                mdio_oe = 1'b1;
                mdio_o  = tx_sh[31];
            end
            S_DONE: begin
                done = 1'b1;
                run  = 1'b0;
            end
            default: ;
        endcase
    end

    assign err   = err_q;
    assign rdata = rdata_q;

endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
    parameter int HALF_DIV  = 80,
    parameter int PRE_LEN   = 32,
    parameter int FLUSH_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic        req_c45,
    input  logic [4:0]  req_phy,
    input  logic [4:0]  req_dev,
    input  logic [15:0] req_addr,
    input  logic [15:0] req_wdata,
    input  logic [31:0] ta_ignore_mask,
    output logic        ready,
    output logic        done,
    output logic        err,
    output logic [15:0] rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic run;
    logic bit_end;

    mdio_clkgen #(
        .HALF_DIV (HALF_DIV)
    ) u_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .mdc   (mdc),
        .fall  (bit_end)
    );

    mdio_frame_fsm #(
        .PRE_LEN   (PRE_LEN),
        .FLUSH_LEN (FLUSH_LEN),
        .NUM_PHY   (32)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .bit_end        (bit_end),
        .req_valid      (req_valid),
        .req_write      (req_write),
        .req_c45        (req_c45),
        .req_phy        (req_phy),
        .req_dev        (req_dev),
        .req_addr       (req_addr),
        .req_wdata      (req_wdata),
        .ta_ignore_mask (ta_ignore_mask),
        .mdio_i         (mdio_i),
        .run            (run),
        .mdio_o         (mdio_o),
        .mdio_oe        (mdio_oe),
        .ready          (ready),
        .done           (done),
        .err            (err),
        .rdata          (rdata)
    );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
    parameter int HALF_DIV = 80
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        ready,
    input logic        done,
    input logic        err,
    input logic [15:0] rdata,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    logic mdc_d;
    int   hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdc_d <= 1'b0;
            hold  <= 0;
        end else begin
            mdc_d <= mdc;
            if (mdc != mdc_d)     hold <= 1;
            else if (hold < HALF_DIV) hold <= hold + 1;
        end
    end

    // R8: each MDC phase lasts at least HALF_DIV system clocks
    a_r8_half_period: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc != mdc_d) |-> (hold >= HALF_DIV));

    // R8: driven data changes only while MDC is low
    a_r8_data_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && $past(mdio_oe) && !$stable(mdio_o)) |-> !mdc);

    // R9: idle means line released and MDC low
    a_r9_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (!mdio_oe && !mdc));

    // R1: an accepted request starts driving preamble ones
    a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid) |=> (!ready && mdio_oe && mdio_o));

    // R10: done is one cycle and ready follows
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && ready));

    // R6: an error completion carries all-ones data
    a_r6_err_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (rdata == 16'hFFFF));

endmodule

bind mdio_master mdio_master_chk #(
    .HALF_DIV (HALF_DIV)
) u_mdio_master_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .ready     (ready),
    .done      (done),
    .err       (err),
    .rdata     (rdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;

    localparam int HALF = 4;
    localparam logic [4:0] BAD_PHY = 5'd7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_c45 = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_dev = '0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [31:0] mask_r = '0;
    logic        ready, done, err, mdc, mdio_o, mdio_oe;
    logic [15:0] rdata;
    logic        mdio_in;
    logic        phy_oe = 1'b0;
    logic        phy_val = 1'b1;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    assign mdio_in = mdio_oe ? mdio_o : (phy_oe ? phy_val : 1'b1);

    mdio_master #(.HALF_DIV(HALF)) dut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_write (req_write),
        .req_c45 (req_c45), .req_phy (req_phy), .req_dev (req_dev),
        .req_addr (req_addr), .req_wdata (req_wdata), .ta_ignore_mask (mask_r),
        .ready (ready), .done (done), .err (err), .rdata (rdata), .mdc (mdc),
        .mdio_o (mdio_o), .mdio_oe (mdio_oe), .mdio_i (mdio_in)
    );

    // ---------------- PHY responder model ----------------
    function automatic logic [15:0] phy_reg(input logic [1:0] st, input logic [4:0] p,
                                            input logic [4:0] r, input logic [15:0] a45);
        if (st == 2'b01) return {p, r, 6'h2B} ^ 16'h5A00;
        else             return a45 ^ {p, r, 6'h11};
    endfunction

    int          ones = 0, hcnt = 0, wcnt = 0, resp_cnt = 0, pmode = 0;
    int          frames = 0, pre_bad = 0, proto_bad = 0, rise_cnt = 0;
    logic [13:0] hdr = '0;
    logic [17:0] wsh = '0;
    logic [16:0] rsh = '0;
    logic [3:0]  last_stop = '0, prev_stop = '0;
    logic [4:0]  phy_last = '0, reg_last = '0;
    logic [1:0]  ta_last = '0;
    logic [15:0] wd_last = '0, c45_addr = '0;

    always @(posedge mdc) begin
        rise_cnt++;
        if (resp_cnt > 0) begin
            phy_oe  <= 1'b1;
            phy_val <= rsh[16];
            rsh = {rsh[15:0], 1'b0};
            resp_cnt--;
        end else begin
            phy_oe <= 1'b0;
        end
        if (mdio_oe) begin
            case (pmode)
                0: begin
                    if (mdio_o) ones++;
                    else begin
                        if (ones != 32) pre_bad++;
                        ones = 0; hdr = '0; hcnt = 1; pmode = 1;
                    end
                end
                1: begin
                    hdr = {hdr[12:0], mdio_o};
                    hcnt++;
                    if (hcnt == 14) begin
                        frames++;
                        prev_stop = last_stop;
                        last_stop = hdr[13:10];
                        phy_last  = hdr[9:5];
                        reg_last  = hdr[4:0];
                        if (hdr[13:10] == 4'b0110 || hdr[13:10] == 4'b0011) begin
                            rsh = {(hdr[9:5] == BAD_PHY),
                                   phy_reg(hdr[13:12], hdr[9:5], hdr[4:0], c45_addr)};
                            resp_cnt = 17;
                            pmode = 0;
                        end else begin
                            wcnt = 0; pmode = 2;
                        end
                    end
                end
                default: begin
                    wsh = {wsh[16:0], mdio_o};
                    wcnt++;
                    if (wcnt == 18) begin
                        ta_last = wsh[17:16];
                        wd_last = wsh[15:0];
                        if (last_stop == 4'b0000) c45_addr = wsh[15:0];
                        pmode = 0;
                    end
                end
            endcase
        end else begin
            ones = 0;
            if (pmode != 0) begin proto_bad++; pmode = 0; end
        end
    end

    // ---------------- line and MDC monitors ----------------
    int   cyc = 0, last_t = -1, gap_bad = 0, gap_seen = 0, conflict = 0;
    logic mprev = 1'b0;
    always @(negedge clk) begin
        cyc++;
        if (mdio_oe && phy_oe) conflict++;
        if (ready) last_t = -1;
        else if (mdc !== mprev) begin
            if (last_t >= 0) begin
                gap_seen++;
                if (cyc - last_t != HALF) gap_bad++;
            end
            last_t = cyc;
        end
        mprev = mdc;
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic wr, input logic c45, input logic [4:0] p,
                          input logic [4:0] d, input logic [15:0] a, input logic [15:0] wd,
                          input logic [31:0] m, output logic [15:0] rd, output logic er,
                          output int rises);
        int r0;
        int n;
        @(negedge clk);
        mask_r = m; req_write = wr; req_c45 = c45; req_phy = p; req_dev = d;
        req_addr = a; req_wdata = wd; req_valid = 1'b1;
        r0 = rise_cnt;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        if (n >= 5000) chk("R10 done timeout", 0, 1);
        rd = rdata; er = err; rises = rise_cnt - r0;
        @(negedge clk);
        chk("R10 done one cycle", done, 1'b0);
        chk("R10 ready after done", ready, 1'b1);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R9 oe low after reset", mdio_oe, 1'b0);
        chk("R8 mdc idles low", mdc, 1'b0);
        chk("R1 ready after reset", ready, 1'b1);
        chk("R10 done low after reset", done, 1'b0);
    endtask

    task automatic t_c22_read();
        logic [15:0] rd; logic er; int rs;
        run_op(1'b0, 1'b0, 5'd3, 5'd2, 16'h0, 16'h0, 32'h0, rd, er, rs);
        chk("R5 c22 read data", rd, phy_reg(2'b01, 5'd3, 5'd2, 16'h0));
        chk("R5 c22 read err", er, 1'b0);
        chk("R5 c22 read edges", rs, 64);
        chk("R2 c22 read start/op", last_stop, 4'b0110);
        chk("R2 c22 read phy", phy_last, 5'd3);
        chk("R2 c22 read reg", reg_last, 5'd2);
        chk("R1 preamble 32 ones", pre_bad, 0);
    endtask

    task automatic t_c22_write();
        logic [15:0] rd; logic er; int rs;
        run_op(1'b1, 1'b0, 5'd17, 5'd9, 16'h0, 16'hA5C3, 32'h0, rd, er, rs);
        chk("R2 c22 write start/op", last_stop, 4'b0101);
        chk("R2 c22 write phy", phy_last, 5'd17);
        chk("R2 c22 write reg", reg_last, 5'd9);
        chk("R4 write turnaround", ta_last, 2'b10);
        chk("R4 write data", wd_last, 16'hA5C3);
        chk("R4 c22 write edges", rs, 65);
    endtask

    task automatic t_edge_fields();
        logic [15:0] rd; logic er; int rs;
        run_op(1'b0, 1'b0, 5'd31, 5'd31, 16'h0, 16'h0, 32'h0, rd, er, rs);
        chk("R2 max phy field", phy_last, 5'd31);
        chk("R2 max reg field", reg_last, 5'd31);
        chk("R5 max field read data", rd, phy_reg(2'b01, 5'd31, 5'd31, 16'h0));
    endtask

    task automatic t_c45_write();
        logic [15:0] rd; logic er; int rs; int f0;
        f0 = frames;
        run_op(1'b1, 1'b1, 5'd5, 5'd3, 16'h1234, 16'hBEEF, 32'h0, rd, er, rs);
        chk("R3 c45 write two frames", frames - f0, 2);
        chk("R3 c45 address frame start/op", prev_stop, 4'b0000);
        chk("R3 c45 address value", c45_addr, 16'h1234);
        chk("R3 c45 write start/op", last_stop, 4'b0001);
        chk("R3 c45 device field", reg_last, 5'd3);
        chk("R4 c45 write data", wd_last, 16'hBEEF);
        chk("R4 c45 write edges", rs, 130);
    endtask

    task automatic t_c45_read();
        logic [15:0] rd; logic er; int rs;
        run_op(1'b0, 1'b1, 5'd6, 5'd1, 16'h0042, 16'h0, 32'h0, rd, er, rs);
        chk("R3 c45 read start/op", last_stop, 4'b0011);
        chk("R3 c45 read address", c45_addr, 16'h0042);
        chk("R5 c45 read data", rd, phy_reg(2'b00, 5'd6, 5'd1, 16'h0042));
        chk("R5 c45 read err", er, 1'b0);
        chk("R5 c45 read edges", rs, 129);
    endtask

    task automatic t_bad_ta();
        logic [15:0] rd; logic er; int rs;
        run_op(1'b0, 1'b0, BAD_PHY, 5'd4, 16'h0, 16'h0, 32'h0, rd, er, rs);
        chk("R6 flush data all ones", rd, 16'hFFFF);
        chk("R6 flush err", er, 1'b1);
        chk("R6 flush edges", rs, 79);
        run_op(1'b0, 1'b0, BAD_PHY, 5'd4, 16'h0, 16'h0, 32'h1 << 8, rd, er, rs);
        chk("R7 other phy mask bit has no effect", er, 1'b1);
        chk("R7 other phy mask bit data", rd, 16'hFFFF);
    endtask

    task automatic t_mask();
        logic [15:0] rd; logic er; int rs;
        run_op(1'b0, 1'b0, BAD_PHY, 5'd4, 16'h0, 16'h0, 32'h1 << 7, rd, er, rs);
        chk("R7 masked read data", rd, phy_reg(2'b01, BAD_PHY, 5'd4, 16'h0));
        chk("R7 masked read err", er, 1'b0);
        chk("R7 masked read edges", rs, 64);
    endtask

    task automatic t_busy_ignore();
        int f0;
        int n;
        f0 = frames;
        @(negedge clk);
        mask_r = '0; req_write = 1'b0; req_c45 = 1'b0; req_phy = 5'd4; req_dev = 5'd1;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (60) @(negedge clk);
        req_write = 1'b1; req_phy = 5'd9; req_wdata = 16'h1111; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        chk("R10 busy request keeps read data", rdata, phy_reg(2'b01, 5'd4, 5'd1, 16'h0));
        repeat (600) @(negedge clk);
        chk("R10 busy request starts no frame", frames - f0, 1);
        chk("R10 busy request leaves fields", phy_last, 5'd4);
        chk("R10 idle after ignored request", ready, 1'b1);
    endtask

    // ---------------- main sequence ----------------
    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_c22_read();
        t_c22_write();
        t_edge_fields();
        t_c45_write();
        t_c45_read();
        t_bad_ta();
        t_mask();
        t_busy_ignore();
        chk("R8 mdc phase length", gap_bad, 0);
        chk("R8 mdc phases observed", (gap_seen > 1000) ? 1 : 0, 1);
        chk("R9 no drive conflict", conflict, 0);
        chk("R9 no frame cut short", proto_bad, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule